// File: doc/BRIEF.md
# Video Register Shadow with Write Guard

This block sits on the control port between a CPU and a video display processor. Register writes on that port are write-only. The block decodes each two-byte register-write sequence and forwards the finished write to the video chip as one register-number/data pair. It also keeps a readable shadow copy of every value that reaches the chip. Software can read the whole shadow, save it, and later replay it, which lets screen ownership pass from one program to another and back. A per-register dirty flag marks the entries written since software last cleared the flags.

A guard can be switched on for the upper register range. In trap mode, a write to a guarded register does not complete. Instead it raises a fault and is held in a single holding slot. The control port stalls until software approves the write, which forwards it, or denies it, which discards it. In drop mode, guarded writes are discarded with no fault. Registers below the guard base always pass.

Top module: `vreg_shadow_guard`

## Requirements
- R1: After reset, no register write is issued, the fault flag is 0, the control port is ready, every shadow entry reads 0 and every dirty flag reads 0.
- R2: A data byte followed by a second byte whose bits [7:6] are 2'b10 issues exactly one register write to the video port. The register number is bits [5:0] of the second byte and the value is the first byte. The write appears on the cycle after the second byte is accepted.
- R3: A second byte whose bits [7:6] are not 2'b10 issues no register write, and the next byte is again taken as a first byte.
- R4: A status-read strobe returns the byte sequence to the first byte.
- R5: Every write issued to the video port is stored in the shadow entry of its register number, readable on the shadow read port, and sets that entry's dirty flag.
- R6: A dirty-clear pulse clears every dirty flag and leaves the shadow values unchanged.
- R7: With the guard disabled, writes to all 64 registers are issued.
- R8: With the guard enabled and drop mode off, a write to register 8 or above raises the fault and is not issued. The fault outputs show the held register and value, and they stay unchanged until the fault is resolved. Registers 0 to 7 are still issued.
- R9: While the fault is pending, the ready output is low and control-port writes are not accepted and have no effect.
- R10: An approve pulse on a pending fault issues the held write on the next cycle, shadows it and clears the fault.
- R11: A deny pulse on a pending fault discards the held write, leaves the shadow unchanged and clears the fault. Deny takes precedence over a simultaneous approve.
- R12: With the guard enabled and drop mode on, writes to register 8 or above are discarded with no fault and no shadow change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | Control-port byte write strobe |
| cpu_wr_data | input | 8 | Control-port byte |
| cpu_wr_ready | output | 1 | Low while a trapped write is pending; writes are not accepted while low |
| cpu_stat_rd | input | 1 | Status-read strobe; resets the byte sequence |
| guard_en | input | 1 | Enables the guard on the upper register range |
| guard_drop | input | 1 | 1: discard guarded writes, 0: trap them |
| fault | output | 1 | A trapped write is pending |
| fault_reg | output | 6 | Register number of the held write |
| fault_data | output | 8 | Value of the held write |
| fault_approve | input | 1 | Forward the held write |
| fault_deny | input | 1 | Discard the held write |
| vdp_we | output | 1 | One-cycle register write to the video chip |
| vdp_reg | output | 6 | Register number of the write |
| vdp_data | output | 8 | Value of the write |
| sh_rd_reg | input | 6 | Shadow read index |
| sh_rd_data | output | 8 | Shadow value of the indexed register |
| sh_rd_dirty | output | 1 | Dirty flag of the indexed register |
| dirty_clr | input | 1 | Clears all dirty flags |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 6-bit register number (64 shadow entries) and a guard base of 8. At this size, every register can be swept in each guard setting. Each entry is written with a value derived from its index, then read back and checked for its dirty flag. Both sides of the guard boundary are checked, as are a deny and an approve raised in the same cycle, and writes presented during a stall.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
   // Marker carried in the top bits of the second byte of a register write
   localparam logic [1:0] REG_TAG = 2'b10;

   typedef enum logic [1:0] {
      ACT_PASS,
      ACT_TRAP,
      ACT_DROP
   } guard_act_e;
endpackage

// File: rtl/vsg_seq.sv
// Control-port byte sequencer: pairs a data byte with a tagged register byte.
module vsg_seq #(
   parameter int DW = 8,
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          ready,
   input  logic          stat_rd,
   output logic          req_valid,
   output logic [AW-1:0] req_reg,
   output logic [DW-1:0] req_data
);
   import vsg_pkg::*;

   if (DW != AW + 2) begin : g_bad_width
      initial $fatal(1, "vsg_seq: DW must equal AW + 2");
   end

   logic          second_q;
   logic [DW-1:0] first_q;
   logic          accept;

   assign accept = wr_en & ready & ~stat_rd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         second_q <= 1'b0;
         first_q  <= '0;
      end else if (stat_rd) begin
         second_q <= 1'b0;
      end else if (accept) begin
         if (!second_q) first_q <= wr_data;
         second_q <= ~second_q;
      end
   end

   assign req_valid = accept & second_q & (wr_data[DW-1 -: 2] == REG_TAG);
   assign req_reg   = wr_data[AW-1:0];
   assign req_data  = first_q;
endmodule

// File: rtl/vsg_gate.sv
// Guard policy: pass, trap-and-hold, or drop each decoded register write.
module vsg_gate #(
   parameter int DW         = 8,
   parameter int AW         = 6,
   parameter int GUARD_BASE = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [AW-1:0] req_reg,
   input  logic [DW-1:0] req_data,
   input  logic          guard_en,
   input  logic          guard_drop,
   input  logic          approve,
   input  logic          deny,
   output logic          ready,
   output logic          fault,
   output logic [AW-1:0] hold_reg,
   output logic [DW-1:0] hold_data,
   output logic          fwd_we,
   output logic [AW-1:0] fwd_reg,
   output logic [DW-1:0] fwd_data
);
   import vsg_pkg::*;

   localparam int NREG = 1 << AW;
   localparam logic [AW-1:0] GB = AW'(GUARD_BASE);

   if (GUARD_BASE < 0 || GUARD_BASE >= NREG) begin : g_bad_base
      initial $fatal(1, "vsg_gate: GUARD_BASE outside register range");
   end

   guard_act_e act;
   always_comb begin
      if (guard_en && (req_reg >= GB)) act = guard_drop ? ACT_DROP : ACT_TRAP;
      else                             act = ACT_PASS;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault     <= 1'b0;
         hold_reg  <= '0;
         hold_data <= '0;
         fwd_we    <= 1'b0;
         fwd_reg   <= '0;
         fwd_data  <= '0;
      end else begin
         fwd_we <= 1'b0;
         if (fault) begin
            if (deny) begin
               fault <= 1'b0;
            end else if (approve) begin
               fault    <= 1'b0;
               fwd_we   <= 1'b1;
               fwd_reg  <= hold_reg;
               fwd_data <= hold_data;
            end
         end else if (req_valid) begin
            case (act)
               ACT_PASS: begin
                  fwd_we   <= 1'b1;
                  fwd_reg  <= req_reg;
                  fwd_data <= req_data;
               end
               ACT_TRAP: begin
                  fault     <= 1'b1;
                  hold_reg  <= req_reg;
                  hold_data <= req_data;
               end
               default: ;
            endcase
         end
      end
   end

   assign ready = ~fault;
endmodule

// File: rtl/vsg_store.sv
// Shadow register file with one dirty flag per entry.
module vsg_store #(
   parameter int DW = 8,
   parameter int AW = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [AW-1:0]   wreg,
   input  logic [DW-1:0]   wdata,
   input  logic            dirty_clr,
   input  logic [AW-1:0]   rd_reg,
   output logic [DW-1:0]   rd_data,
   output logic            rd_dirty,
   output logic [(1<<AW)-1:0] dirty_vec
);
   localparam int NREG = 1 << AW;

   logic [DW-1:0] ent_val [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_ent
      logic [DW-1:0] val_q;
      logic          dirty_q;
      logic          hit;
      assign hit = we && (wreg == AW'(i));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            val_q   <= '0;
            dirty_q <= 1'b0;
         end else if (hit) begin
            val_q   <= wdata;
            dirty_q <= 1'b1;
         end else if (dirty_clr) begin
            dirty_q <= 1'b0;
         end
      end
      assign ent_val[i]   = val_q;
      assign dirty_vec[i] = dirty_q;
   end

   assign rd_data  = ent_val[rd_reg];
   assign rd_dirty = dirty_vec[rd_reg];
endmodule

// File: rtl/vreg_shadow_guard.sv
module vreg_shadow_guard #(
   parameter int DW         = 8,
   parameter int AW         = 6,
   parameter int GUARD_BASE = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_wr_en,
   input  logic [DW-1:0] cpu_wr_data,
   output logic          cpu_wr_ready,
   input  logic          cpu_stat_rd,
   input  logic          guard_en,
   input  logic          guard_drop,
   output logic          fault,
   output logic [AW-1:0] fault_reg,
   output logic [DW-1:0] fault_data,
   input  logic          fault_approve,
   input  logic          fault_deny,
   output logic          vdp_we,
   output logic [AW-1:0] vdp_reg,
   output logic [DW-1:0] vdp_data,
   input  logic [AW-1:0] sh_rd_reg,
   output logic [DW-1:0] sh_rd_data,
   output logic          sh_rd_dirty,
   input  logic          dirty_clr
);
   localparam int NREG = 1 << AW;

   logic          req_valid;
   logic [AW-1:0] req_reg;
   logic [DW-1:0] req_data;
   logic [NREG-1:0] dirty_vec;

   vsg_seq #(.DW(DW), .AW(AW)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cpu_wr_en), .wr_data(cpu_wr_data),
      .ready(cpu_wr_ready), .stat_rd(cpu_stat_rd),
      .req_valid(req_valid), .req_reg(req_reg), .req_data(req_data)
   );

   vsg_gate #(.DW(DW), .AW(AW), .GUARD_BASE(GUARD_BASE)) u_gate (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_reg(req_reg), .req_data(req_data),
      .guard_en(guard_en), .guard_drop(guard_drop),
      .approve(fault_approve), .deny(fault_deny),
      .ready(cpu_wr_ready), .fault(fault),
      .hold_reg(fault_reg), .hold_data(fault_data),
      .fwd_we(vdp_we), .fwd_reg(vdp_reg), .fwd_data(vdp_data)
   );

   vsg_store #(.DW(DW), .AW(AW)) u_store (
      .clk(clk), .rst_n(rst_n),
      .we(vdp_we), .wreg(vdp_reg), .wdata(vdp_data),
      .dirty_clr(dirty_clr),
      .rd_reg(sh_rd_reg), .rd_data(sh_rd_data), .rd_dirty(sh_rd_dirty),
      .dirty_vec(dirty_vec)
   );
endmodule

// File: rtl/vsg_checker.sv
module vsg_checker #(
   parameter int DW         = 8,
   parameter int AW         = 6,
   parameter int GUARD_BASE = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fault,
   input logic [AW-1:0]     fault_reg,
   input logic [DW-1:0]     fault_data,
   input logic              fault_approve,
   input logic              fault_deny,
   input logic              vdp_we,
   input logic [AW-1:0]     vdp_reg,
   input logic [DW-1:0]     vdp_data,
   input logic [(1<<AW)-1:0] dirty_vec
);
   localparam logic [AW-1:0] GB = AW'(GUARD_BASE);

   a_r5_dirty_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      vdp_we |=> dirty_vec[$past(vdp_reg)]);

   a_r8_trap_upper_only: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault) |-> (fault_reg >= GB) && !vdp_we);

   a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      fault && !fault_approve && !fault_deny |=>
         fault && $stable(fault_reg) && $stable(fault_data));

   a_r9_no_write_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
      fault && !fault_approve |=> !vdp_we);

   a_r10_approve_forwards: assert property (@(posedge clk) disable iff (!rst_n)
      fault && fault_approve && !fault_deny |=>
         vdp_we && !fault && vdp_reg == $past(fault_reg) && vdp_data == $past(fault_data));

   a_r11_deny_drops: assert property (@(posedge clk) disable iff (!rst_n)
      fault && fault_deny |=> !vdp_we && !fault);
endmodule

bind vreg_shadow_guard vsg_checker #(.DW(DW), .AW(AW), .GUARD_BASE(GUARD_BASE)) u_chk (
   .clk(clk), .rst_n(rst_n), .fault(fault), .fault_reg(fault_reg),
   .fault_data(fault_data), .fault_approve(fault_approve), .fault_deny(fault_deny),
   .vdp_we(vdp_we), .vdp_reg(vdp_reg), .vdp_data(vdp_data), .dirty_vec(dirty_vec)
);

// File: tb/test_vreg_shadow_guard.sv
`timescale 1ns/1ps
module test_vreg_shadow_guard;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_wr_en = 1'b0;
   logic [7:0] cpu_wr_data = '0;
   logic       cpu_wr_ready;
   logic       cpu_stat_rd = 1'b0;
   logic       guard_en = 1'b0;
   logic       guard_drop = 1'b0;
   logic       fault;
   logic [5:0] fault_reg;
   logic [7:0] fault_data;
   logic       fault_approve = 1'b0;
   logic       fault_deny = 1'b0;
   logic       vdp_we;
   logic [5:0] vdp_reg;
   logic [7:0] vdp_data;
   logic [5:0] sh_rd_reg = '0;
   logic [7:0] sh_rd_data;
   logic       sh_rd_dirty;
   logic       dirty_clr = 1'b0;

   int checks = 0;
   int errors = 0;
   int fwd_cnt = 0;
   int last_reg = -1;
   int last_data = -1;

   always #5 clk = ~clk;

   vreg_shadow_guard i_vreg_shadow_guard (.*);

   // Count issued writes shortly after each edge
   always @(posedge clk) begin
      #2;
      if (vdp_we) begin
         fwd_cnt++;
         last_reg  = vdp_reg;
         last_data = vdp_data;
      end
   end

   function automatic int val_of(input int r, input int salt);
      return (r * 37 + 11 + salt) & 255;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_byte(input logic [7:0] b);
      @(negedge clk);
      while (!cpu_wr_ready) @(negedge clk);
      cpu_wr_en = 1'b1; cpu_wr_data = b;
      @(negedge clk);
      cpu_wr_en = 1'b0;
   endtask

   task automatic reg_write(input int r, input int d);
      wr_byte(8'(d));
      wr_byte(8'h80 | 8'(r));
   endtask

   task automatic rd_shadow(input int r, output int d, output int dt);
      @(negedge clk);
      sh_rd_reg = 6'(r);
      #1;
      d = sh_rd_data; dt = sh_rd_dirty;
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk); s = 1'b1;
      @(negedge clk); s = 1'b0;
   endtask

   int d, dt, c0;

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!fault && cpu_wr_ready && !vdp_we, "R1 outputs", {fault, cpu_wr_ready, vdp_we}, 3'b010);
      for (int r = 0; r < 64; r++) begin
         rd_shadow(r, d, dt);
         chk(d == 0 && dt == 0, "R1 shadow", d, 0);
      end

      // R2, R7: guard off, every register issued
      for (int r = 0; r < 64; r++) begin
         c0 = fwd_cnt;
         reg_write(r, val_of(r, 0));
         chk(fwd_cnt == c0 + 1, "R7 issued", fwd_cnt - c0, 1);
         chk(last_reg == r && last_data == val_of(r, 0), "R2 pair", last_data, val_of(r, 0));
      end
      // R5 shadow and dirty
      for (int r = 0; r < 64; r++) begin
         rd_shadow(r, d, dt);
         chk(d == val_of(r, 0) && dt == 1, "R5 shadow", d, val_of(r, 0));
      end

      // R6 dirty clear
      pulse(dirty_clr);
      for (int r = 0; r < 64; r++) begin
         rd_shadow(r, d, dt);
         chk(dt == 0 && d == val_of(r, 0), "R6 cleared", dt, 0);
      end

      // R3 untagged second byte
      c0 = fwd_cnt;
      wr_byte(8'h55); wr_byte(8'h45);
      repeat (2) @(negedge clk);
      chk(fwd_cnt == c0, "R3 no write", fwd_cnt - c0, 0);
      reg_write(3, 8'h12);
      chk(fwd_cnt == c0 + 1 && last_reg == 3 && last_data == 8'h12, "R3 resync", last_data, 8'h12);

      // R4 status read resets sequence
      wr_byte(8'hAA);
      pulse(cpu_stat_rd);
      c0 = fwd_cnt;
      reg_write(4, 8'h21);
      chk(fwd_cnt == c0 + 1 && last_reg == 4 && last_data == 8'h21, "R4 restart", last_data, 8'h21);

      // R8 trap mode: lower range passes
      guard_en = 1'b1; guard_drop = 1'b0;
      for (int r = 0; r < 8; r++) begin
         c0 = fwd_cnt;
         reg_write(r, val_of(r, 1));
         chk(fwd_cnt == c0 + 1 && last_reg == r, "R8 lower pass", last_reg, r);
      end
      c0 = fwd_cnt;
      reg_write(9, 8'h3C);
      chk(fault && fault_reg == 9 && fault_data == 8'h3C, "R8 held", {fault_reg, fault_data}, {6'd9, 8'h3C});
      chk(fwd_cnt == c0 && !cpu_wr_ready, "R8 not issued", fwd_cnt - c0, 0);

      // R9 writes while stalled
      @(negedge clk); cpu_wr_en = 1'b1; cpu_wr_data = 8'h77;
      @(negedge clk); cpu_wr_data = 8'h81;
      @(negedge clk); cpu_wr_en = 1'b0;
      @(negedge clk);
      chk(fwd_cnt == c0 && fault && fault_reg == 9 && fault_data == 8'h3C, "R9 stalled", fault_data, 8'h3C);

      // R10 approve
      pulse(fault_approve);
      chk(fwd_cnt == c0 + 1 && last_reg == 9 && last_data == 8'h3C && !fault, "R10 forwarded", last_data, 8'h3C);
      rd_shadow(9, d, dt);
      chk(d == 8'h3C && dt == 1, "R10 shadow", d, 8'h3C);
      // sequence intact after stall (R9)
      reg_write(2, 8'h66);
      chk(last_reg == 2 && last_data == 8'h66, "R9 sequence intact", last_data, 8'h66);

      // R11 deny wins over approve
      c0 = fwd_cnt;
      reg_write(20, 8'h99);
      chk(fault && fault_reg == 20, "R11 trapped", fault_reg, 20);
      @(negedge clk); fault_deny = 1'b1; fault_approve = 1'b1;
      @(negedge clk); fault_deny = 1'b0; fault_approve = 1'b0;
      @(negedge clk);
      chk(fwd_cnt == c0 && !fault, "R11 dropped", fwd_cnt - c0, 0);
      rd_shadow(20, d, dt);
      chk(d == val_of(20, 0), "R11 shadow kept", d, val_of(20, 0));

      // R12 drop mode
      guard_drop = 1'b1;
      for (int r = 8; r < 64; r++) begin
         c0 = fwd_cnt;
         reg_write(r, val_of(r, 2));
         @(negedge clk);
         chk(fwd_cnt == c0 && !fault, "R12 discarded", fwd_cnt - c0, 0);
      end
      for (int r = 8; r < 64; r++) begin
         rd_shadow(r, d, dt);
         chk(d == (r == 9 ? 8'h3C : val_of(r, 0)), "R12 shadow kept", d, r == 9 ? 8'h3C : val_of(r, 0));
      end
      c0 = fwd_cnt;
      reg_write(7, 8'h5A);
      chk(fwd_cnt == c0 + 1 && last_reg == 7, "R12 lower pass", last_reg, 7);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule